// File: doc/BRIEF.md
# Three-Channel Interval Timer Bus Front End

This block is the byte-wide register front end of a three-channel interval timer. A host drives single-cycle write and read strobes with a 2-bit address. Addresses 0, 1 and 2 reach the data ports of the three channels. Address 3 is a control port that accepts writes only. The counting engines sit outside this block. The block hands each completed 16-bit reload value to its channel as a one-cycle strobe. It takes in each channel's live count and output level.

A control word sets up a channel. It picks how the 16-bit count travels over the 8-bit bus: low byte only, high byte only, or low byte followed by high byte. It also carries the counting mode and the decimal flag, which are passed on to the channel. Each channel keeps its own byte sequencers for reads and writes. It also has a one-shot count snapshot and a one-shot status snapshot. Snapshots can be requested for one channel, or for several channels at once through a read-back command. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `ivt_regif`

## Requirements
- R1: After reset, `rdata` is 0 and `load_stb` is 0. Every channel has counting mode 0, the decimal flag clear and byte order low-then-high, with both sequencers at the low byte.
- R2: A write to address 3 is a control word. Bits 7:6 name the channel, bits 5:4 the byte order, bits 3:1 the counting mode and bit 0 the decimal flag. When bits 7:6 are below 3 and bits 5:4 are non-zero, the word stores the byte order, mode and flag for that channel. It also returns both byte sequencers of that channel to the low byte. A control word never pulses `load_stb`.
- R3: The byte-order codes are 1 (low only), 2 (high only) and 3 (low then high). In low-only order, a data write loads `{8'h00, byte}`. In high-only order, it loads `{byte, 8'h00}`. The load appears as a one-cycle `load_stb` pulse on the written channel only, in the cycle after the write.
- R4: In low-then-high order, the first data write is held and gives no load. The second write loads `{second, first}`.
- R5: With no snapshot pending, a data read returns the live count. Low-only order gives bits 7:0 and high-only order gives bits 15:8. Low-then-high order alternates low, high, low and so on.
- R6: A control word with bits 5:4 equal to 0 captures the channel's live count as it is in the write cycle. Later reads return the captured bytes in the channel's byte order. The snapshot is released after its last byte has been read, and reads then follow the live count again.
- R7: A count capture request made while a captured count is still unread is ignored.
- R8: The status byte holds the output level in bit 7 and 0 in bit 6. Bits 5:4 hold the byte order, bits 3:1 the counting mode and bit 0 the decimal flag, all captured when the status is requested. A read of a pending status returns it and clears it.
- R9: A pending status is read before a pending captured count.
- R10: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2, in any combination. Bit 5 at 0 requests a count capture and bit 4 at 0 requests a status capture. Channels that are not selected are untouched.
- R11: A status request made while a status is still pending is ignored.
- R12: A read of address 3 returns 0. `rdata` changes only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Port select: 0 to 2 are data ports, 3 is the control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| live_cnt | input | 48 | Live count of each channel, channel i at bits 16i+15:16i |
| out_lvl | input | 3 | Output level of each channel |
| load_stb | output | 3 | One-cycle reload strobe per channel |
| load_val | output | 48 | Reload value per channel, channel i at bits 16i+15:16i |
| cnt_mode | output | 9 | Counting mode per channel, channel i at bits 3i+2:3i |
| cnt_bcd | output | 3 | Decimal flag per channel |

## Verification
Each byte order is used for writes and for live reads. Comparing them shows whether the byte is placed in the right half of the word, and whether the low-then-high sequencers alternate and return to the low byte after a fresh control word. Count snapshots are taken and then the live inputs are changed. This separates captured data from live data, and a second request that must be ignored shows whether the snapshot is taken only once. Read-back commands select several channels, or ask for the status twice with a changed output level in between. These cases check the channel selection, the order in which status and count are read out, and whether the first status is kept.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BW     = 8;   // bus byte width
  localparam int CW     = 16;  // count width
  localparam int MW     = 3;   // counting mode width
  localparam int NCH    = 3;   // channels
  localparam int AW     = 2;   // address width
  localparam int NPORT  = 1 << AW;

  // byte order codes; BS_NONE doubles as "count capture / nothing pending"
  typedef enum logic [1:0] {
    BS_NONE = 2'd0,
    BS_LO   = 2'd1,
    BS_HI   = 2'd2,
    BS_LH   = 2'd3
  } byte_sel_e;

  function automatic logic [BW-1:0] status_byte(input logic lvl, input byte_sel_e bs,
                                                input logic [MW-1:0] md, input logic dec);
    return {lvl, 1'b0, bs, md, dec};
  endfunction

  function automatic logic [CW-1:0] load_word(input byte_sel_e bs, input logic [BW-1:0] held,
                                              input logic [BW-1:0] b);
    case (bs)
      BS_LO:   return {{(CW-BW){1'b0}}, b};
      BS_HI:   return {b, {(CW-BW){1'b0}}};
      default: return {b, held};
    endcase
  endfunction

  function automatic logic [BW-1:0] byte_of(input logic [CW-1:0] w, input logic hi);
    return hi ? w[CW-1:BW] : w[BW-1:0];
  endfunction
endpackage

// File: rtl/ivt_ctl_decode.sv
module ivt_ctl_decode
  import ivt_pkg::*;
(
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [BW-1:0]   wdata,
  output logic            ctl_wr,
  output byte_sel_e       new_bs,
  output logic [NCH-1:0]  ctl_set,
  output logic [NCH-1:0]  cap_cnt,
  output logic [NCH-1:0]  cap_st,
  output logic [NCH-1:0]  dat_wr,
  output logic [NCH-1:0]  dat_rd
);
  localparam logic [AW-1:0] CTL_ADDR = AW'(NPORT - 1);

  logic          readback;
  logic [AW-1:0] sel;

  assign ctl_wr   = wr_en && (addr == CTL_ADDR);
  assign sel      = wdata[7:6];
  assign readback = (sel == CTL_ADDR);
  assign new_bs   = byte_sel_e'(wdata[5:4]);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit, rb_hit;
    assign hit        = ctl_wr && !readback && (sel == AW'(i));
    assign rb_hit     = ctl_wr && readback && wdata[i+1];
    assign ctl_set[i] = hit && (new_bs != BS_NONE);
    assign cap_cnt[i] = (hit && (new_bs == BS_NONE)) || (rb_hit && !wdata[5]);
    assign cap_st[i]  = rb_hit && !wdata[4];
    assign dat_wr[i]  = wr_en && (addr == AW'(i));
    assign dat_rd[i]  = rd_en && (addr == AW'(i));
  end
endmodule

// File: rtl/ivt_chan_port.sv
module ivt_chan_port
  import ivt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_set,
  input  byte_sel_e       new_bs,
  input  logic [MW-1:0]   new_mode,
  input  logic            new_bcd,
  input  logic            cap_cnt,
  input  logic            cap_st,
  input  logic            dat_wr,
  input  logic            dat_rd,
  input  logic [BW-1:0]   wdata,
  input  logic [CW-1:0]   live_cnt,
  input  logic            out_lvl,
  output logic [BW-1:0]   rd_byte,
  output logic            load_stb,
  output logic [CW-1:0]   load_val,
  output logic [MW-1:0]   mode,
  output logic            bcd,
  output logic            cnt_held,
  output logic            st_held
);
  byte_sel_e       bs, snap_bs;
  logic            wr_hi, rd_hi;
  logic [BW-1:0]   held;
  logic [CW-1:0]   snap_cnt;
  logic [BW-1:0]   snap_st;

  assign cnt_held = (snap_bs != BS_NONE);

  always_comb begin
    if (st_held)       rd_byte = snap_st;
    else if (cnt_held) rd_byte = byte_of(snap_cnt, snap_bs == BS_HI);
    else               rd_byte = byte_of(live_cnt, (bs == BS_HI) || ((bs == BS_LH) && rd_hi));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bs       <= BS_LH;
      mode     <= '0;
      bcd      <= 1'b0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      held     <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
      snap_bs  <= BS_NONE;
      snap_cnt <= '0;
      st_held  <= 1'b0;
      snap_st  <= '0;
    end else begin
      load_stb <= 1'b0;
      if (dat_wr) begin
        if ((bs == BS_LH) && !wr_hi) begin
          held  <= wdata;
          wr_hi <= 1'b1;
        end else begin
          load_val <= load_word(bs, held, wdata);
          load_stb <= 1'b1;
          wr_hi    <= 1'b0;
        end
      end
      if (dat_rd) begin
        if (st_held)           st_held <= 1'b0;
        else if (cnt_held)     snap_bs <= (snap_bs == BS_LH) ? BS_HI : BS_NONE;
        else if (bs == BS_LH)  rd_hi   <= ~rd_hi;
      end
      if (ctl_set) begin
        bs    <= new_bs;
        mode  <= new_mode;
        bcd   <= new_bcd;
        wr_hi <= 1'b0;
        rd_hi <= 1'b0;
      end
      if (cap_cnt && !cnt_held) begin
        snap_cnt <= live_cnt;
        snap_bs  <= bs;
      end
      if (cap_st && !st_held) begin
        snap_st <= status_byte(out_lvl, bs, mode, bcd);
        st_held <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivt_regif.sv
module ivt_regif
  import ivt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [BW-1:0]      wdata,
  output logic [BW-1:0]      rdata,
  input  logic [NCH*CW-1:0]  live_cnt,
  input  logic [NCH-1:0]     out_lvl,
  output logic [NCH-1:0]     load_stb,
  output logic [NCH*CW-1:0]  load_val,
  output logic [NCH*MW-1:0]  cnt_mode,
  output logic [NCH-1:0]     cnt_bcd
);
  logic                       ctl_wr;
  byte_sel_e                  new_bs;
  logic [NCH-1:0]             ctl_set, cap_cnt, cap_st, dat_wr, dat_rd;
  logic [NCH-1:0]             cnt_held, st_held;
  logic [NPORT-1:0][BW-1:0]   rd_bus;

  ivt_ctl_decode u_dec (
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .ctl_wr  (ctl_wr),
    .new_bs  (new_bs),
    .ctl_set (ctl_set),
    .cap_cnt (cap_cnt),
    .cap_st  (cap_st),
    .dat_wr  (dat_wr),
    .dat_rd  (dat_rd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ivt_chan_port u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_set  (ctl_set[i]),
      .new_bs   (new_bs),
      .new_mode (wdata[3:1]),
      .new_bcd  (wdata[0]),
      .cap_cnt  (cap_cnt[i]),
      .cap_st   (cap_st[i]),
      .dat_wr   (dat_wr[i]),
      .dat_rd   (dat_rd[i]),
      .wdata    (wdata),
      .live_cnt (live_cnt[i*CW +: CW]),
      .out_lvl  (out_lvl[i]),
      .rd_byte  (rd_bus[i]),
      .load_stb (load_stb[i]),
      .load_val (load_val[i*CW +: CW]),
      .mode     (cnt_mode[i*MW +: MW]),
      .bcd      (cnt_bcd[i]),
      .cnt_held (cnt_held[i]),
      .st_held  (st_held[i])
    );
  end

  for (genvar p = NCH; p < NPORT; p++) begin : g_pad
    assign rd_bus[p] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_bus[addr];
  end
endmodule

// File: rtl/ivt_regif_chk.sv
module ivt_regif_chk
  import ivt_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [BW-1:0]   rdata,
  input logic [NCH-1:0]  load_stb,
  input logic            ctl_wr,
  input logic [NCH-1:0]  cnt_held,
  input logic [NCH-1:0]  st_held
);
  localparam logic [AW-1:0] CTL_ADDR = AW'(NPORT - 1);

  // R12
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == CTL_ADDR) |=> (rdata == '0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  // R2
  ctl_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (load_stb == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch_chk
    // R3
    load_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb[i] |-> $past(wr_en && addr == AW'(i)));

    // R7
    cnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_held[i] && !(rd_en && addr == AW'(i))) |=> cnt_held[i]);

    // R11
    st_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_held[i] && !(rd_en && addr == AW'(i))) |=> st_held[i]);
  end
endmodule

bind ivt_regif ivt_regif_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .load_stb (load_stb),
  .ctl_wr   (ctl_wr),
  .cnt_held (cnt_held),
  .st_held  (st_held)
);

// File: tb/ivt_regif_bench.sv
module ivt_regif_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = '0;
  logic [2:0]  out_lvl = '0;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [8:0]  cnt_mode;
  logic [2:0]  cnt_bcd;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       mon_due = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivt_regif u_ivt_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .out_lvl(out_lvl),
    .load_stb(load_stb), .load_val(load_val), .cnt_mode(cnt_mode), .cnt_bcd(cnt_bcd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    live_cnt[ch*16 +: 16] = v;
  endtask

  // scoreboard monitor
  always @(posedge clk) mon_due <= rd_en;
  always @(negedge clk) begin
    if (mon_due) begin
      if (exp_q.size() == 0) check("read with no expectation", 32'(rdata), 32'hFFFF_FFFF);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(rdata), 32'(e));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    set_live(0, 16'h1234); set_live(1, 16'hBEEF); set_live(2, 16'hCAFE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rdata", 32'(rdata), 0);
    check("R1 load_stb", 32'(load_stb), 0);
    check("R1 mode", 32'(cnt_mode), 0);
    check("R1 bcd", 32'(cnt_bcd), 0);
    rd(0, 8'h34, "R1 low-then-high default low");
    rd(0, 8'h12, "R1 low-then-high default high");

    // R2 decode, R3 low-only
    wr(3, 8'h17);
    check("R2 ctl no load", 32'(load_stb), 0);
    check("R2 mode ch0", 32'(cnt_mode[2:0]), 3);
    check("R2 bcd ch0", 32'(cnt_bcd[0]), 1);
    wr(0, 8'h5A);
    check("R3 low-only stb", 32'(load_stb), 32'b001);
    check("R3 low-only val", 32'(load_val[15:0]), 32'h005A);
    rd(0, 8'h34, "R5 low-only live");
    rd(0, 8'h34, "R5 low-only live again");

    // R3 high-only
    wr(3, 8'h62);
    check("R2 mode ch1", 32'(cnt_mode[5:3]), 1);
    wr(1, 8'hA5);
    check("R3 high-only stb", 32'(load_stb), 32'b010);
    check("R3 high-only val", 32'(load_val[31:16]), 32'hA500);
    rd(1, 8'hBE, "R5 high-only live");

    // R4 low-then-high writes, R5 alternating reads
    wr(3, 8'hB4);
    wr(2, 8'h11);
    check("R4 first byte no load", 32'(load_stb), 0);
    wr(2, 8'h22);
    check("R4 second byte stb", 32'(load_stb), 32'b100);
    check("R4 word", 32'(load_val[47:32]), 32'h2211);
    rd(2, 8'hFE, "R5 alt low");
    rd(2, 8'hCA, "R5 alt high");
    rd(2, 8'hFE, "R5 alt low again");
    wr(2, 8'h33);
    wr(3, 8'hB4);
    wr(2, 8'h44);
    check("R2 write sequencer reset", 32'(load_stb), 0);
    wr(2, 8'h55);
    check("R2 reloaded word", 32'(load_val[47:32]), 32'h5544);
    rd(2, 8'hFE, "R2 read sequencer reset");

    // R6 / R7 count capture on ch2 (low-then-high)
    wr(3, 8'hB4);
    set_live(2, 16'h1357);
    wr(3, 8'h80);
    set_live(2, 16'h9A8B);
    wr(3, 8'h80);
    rd(2, 8'h57, "R7 first capture kept low");
    rd(2, 8'h13, "R6 captured high");
    rd(2, 8'h8B, "R6 released live low");
    rd(2, 8'h9A, "R6 released live high");

    // R6 low-only capture on ch0
    set_live(0, 16'h4321);
    wr(3, 8'h00);
    set_live(0, 16'h5555);
    rd(0, 8'h21, "R6 low-only captured");
    rd(0, 8'h55, "R6 low-only released");

    // R8 / R11 status on ch1
    out_lvl = 3'b010;
    wr(3, 8'hE4);
    out_lvl = 3'b000;
    wr(3, 8'hE4);
    rd(1, 8'hA2, "R11 first status kept, R8 format");
    rd(1, 8'hBE, "R8 status cleared after read");

    // R9 / R10 read-back of ch0 and ch2, count and status
    out_lvl = 3'b100;
    set_live(0, 16'h0A0B); set_live(2, 16'h0C0D);
    wr(3, 8'hCA);
    set_live(0, 16'hFFF0); set_live(2, 16'h7777);
    rd(0, 8'h17, "R9 ch0 status first");
    rd(0, 8'h0B, "R10 ch0 captured low");
    rd(0, 8'hF0, "R10 ch0 released");
    rd(2, 8'hB4, "R9 ch2 status first");
    rd(2, 8'h0D, "R10 ch2 captured low");
    rd(2, 8'h0C, "R10 ch2 captured high");
    rd(2, 8'h77, "R10 ch2 released");
    rd(1, 8'hBE, "R10 ch1 unselected");

    // R12 control port reads and hold
    rd(3, 8'h00, "R12 control read zero");
    rd(0, 8'hF0, "R12 data before hold");
    repeat (4) @(negedge clk);
    check("R12 rdata held", 32'(rdata), 32'hF0);
    repeat (2) @(negedge clk);
    check("queue drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule